// File: doc/BRIEF.md
# LRU Age-Rank Replacement Tracker

This block keeps the recency order of the lines in one fully associative set and names the line that the next miss should overwrite. Each line has a rank of log2(LINES) bits. Rank 0 is the line used most recently, and larger ranks are older. Tags and data live elsewhere. The surrounding cache gives this block three things: an access strobe, a flag that marks the access as a fill, and the index of the line touched. The tag store also supplies the per-line valid flags every cycle.

On a hit, the touched line moves to rank 0. Lines that were more recent than it move back by one rank, and older lines keep their rank. A fill into an empty line also takes rank 0. In that case the valid lines ranked below the lowest rank value that no valid line holds move back by one, so ranks never overflow, even after lines have been invalidated. The victim output is combinational from the stored ranks and the valid flags. It always names an empty line when one exists. Otherwise it names the oldest line.

Top module: `lru_rank_tracker`

## Requirements
- R1: After reset, line i holds rank i. With all lines valid and no access made, the victim is line LINES-1.
- R2: While any valid flag is 0 (bit i of `line_valid` belongs to line i), the victim is the lowest-numbered line whose flag is 0.
- R3: While all lines are valid, the victim is the line holding rank LINES-1.
- R4: An access with `acc_en`=1 and `acc_fill`=0 to a valid line of rank r does three things on the next edge. The line gets rank 0. Valid lines with rank below r add one. All other lines keep their rank, so touching a rank-0 line changes nothing.
- R5: A fill (`acc_en`=1, `acc_fill`=1) to an invalid line does two things on the next edge. The line gets rank 0. Valid lines ranked below g add one, where g is the lowest rank value held by no valid line.
- R6: A fill to a line that is already valid updates the ranks exactly as R4 does.
- R7: An access with `acc_fill`=0 to an invalid line leaves every rank unchanged.
- R8: Cycles with `acc_en`=0 leave every rank unchanged.
- R9: No two valid lines ever hold the same rank.
- R10: With 4 lines, fill lines 0, 1, 2 and then touch line 0. The ranks become 0, 2, 1 for lines 0, 1, 2. Then fill line 3, and then fill line 1 while the set is full. The ranks become 2, 0, 3, 1 for lines 0 to 3, and the victim is line 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | An access to line `acc_line` occurs this cycle |
| acc_fill | input | 1 | The access writes a new block into the line (miss fill) |
| acc_line | input | log2(LINES) | Index of the line accessed |
| line_valid | input | LINES | Valid flag of each line, bit i for line i |
| victim_line | output | log2(LINES) | Line to overwrite on the next miss |

## Verification
The bound checker tests four things on every cycle. Valid lines never share a rank. A touched valid line drops to rank 0. Lines older than a hit line keep their rank. An access with no fill to an empty line, or a cycle with no access, leaves all ranks frozen. The victim also points at an empty line when one exists, and at the rank LINES-1 line when the set is full. Some effects show only through the order of later victims, and only the bench scenarios can show them. These are: the lowest empty line winning over higher ones, the gap rule for fills after an invalidation, a fill replacing a valid line in the middle of the order, and the full worked sequence of R10.

// File: rtl/lru_rank_pkg.sv
`timescale 1ns/1ps
package lru_rank_pkg;

   // Decoded kind of one access, used to pick the rank threshold
   typedef enum logic [1:0] {
      ACC_IDLE     = 2'd0,
      ACC_HIT      = 2'd1,
      ACC_FILL_NEW = 2'd2,
      ACC_REPLACE  = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e decode_access(input logic en, input logic fill,
                                               input logic tgt_valid);
      if (!en)            return ACC_IDLE;
      else if (!fill)     return tgt_valid ? ACC_HIT : ACC_IDLE;
      else if (tgt_valid) return ACC_REPLACE;
      else                return ACC_FILL_NEW;
   endfunction

endpackage

// File: rtl/lru_free_pick.sv
`timescale 1ns/1ps
module lru_free_pick #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] valid,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx
);

   // Scan from the top so the lowest empty index is the last one written
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/lru_gap_find.sv
`timescale 1ns/1ps
module lru_gap_find #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int GAP_W = IDX_W + 1
) (
   input  logic [LINES*IDX_W-1:0] rank_flat,
   input  logic [LINES-1:0]       valid,
   output logic [GAP_W-1:0]       gap
);

   logic [LINES-1:0] used;

   // Mark the rank values held by valid lines, then take the lowest free one
   always_comb begin
      used = '0;
      for (int i = 0; i < LINES; i++) begin
         if (valid[i]) used[rank_flat[i*IDX_W +: IDX_W]] = 1'b1;
      end
      gap = GAP_W'(LINES);
      for (int v = LINES - 1; v >= 0; v--) begin
         if (!used[v]) gap = GAP_W'(v);
      end
   end

endmodule

// File: rtl/lru_oldest_pick.sv
`timescale 1ns/1ps
module lru_oldest_pick #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic [LINES*IDX_W-1:0] rank_flat,
   output logic [IDX_W-1:0]       old_idx
);

   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

   always_comb begin
      old_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (rank_flat[i*IDX_W +: IDX_W] == OLDEST) old_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/lru_rank_cell.sv
`timescale 1ns/1ps
module lru_rank_cell #(
   parameter int LINES = 4,
   parameter int INIT  = 0,
   localparam int IDX_W = $clog2(LINES),
   localparam int GAP_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             self_sel,
   input  logic             valid,
   input  logic [GAP_W-1:0] thresh,
   output logic [IDX_W-1:0] rank
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rank <= IDX_W'(INIT);
      end else if (upd) begin
         if (self_sel)
            rank <= '0;
         else if (valid && ({1'b0, rank} < thresh))
            rank <= rank + IDX_W'(1);
      end
   end

endmodule

// File: rtl/lru_rank_tracker.sv
`timescale 1ns/1ps
module lru_rank_tracker #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int GAP_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             acc_fill,
   input  logic [IDX_W-1:0] acc_line,
   input  logic [LINES-1:0] line_valid,
   output logic [IDX_W-1:0] victim_line
);
   import lru_rank_pkg::*;

   generate
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         $error("lru_rank_tracker: LINES must be a power of two, at least 2");
      end
   endgenerate

   logic [LINES*IDX_W-1:0] rank_flat;
   logic [IDX_W-1:0]       tgt_rank;
   logic [GAP_W-1:0]       gap;
   logic [GAP_W-1:0]       thresh;
   logic                   upd;
   acc_kind_e              kind;
   logic                   any_free;
   logic [IDX_W-1:0]       free_idx;
   logic [IDX_W-1:0]       old_idx;

   assign tgt_rank = rank_flat[acc_line*IDX_W +: IDX_W];
   assign kind     = decode_access(acc_en, acc_fill, line_valid[acc_line]);
   assign upd      = (kind != ACC_IDLE);

   lru_gap_find #(.LINES(LINES)) u_gap (
      .rank_flat (rank_flat),
      .valid     (line_valid),
      .gap       (gap)
   );

   // A new fill ages lines up to the first unused rank, others up to the target
   always_comb begin
      unique case (kind)
         ACC_FILL_NEW: thresh = gap;
         default:      thresh = {1'b0, tgt_rank};
      endcase
   end

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_cell
         lru_rank_cell #(.LINES(LINES), .INIT(i)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (upd),
            .self_sel (acc_line == IDX_W'(i)),
            .valid    (line_valid[i]),
            .thresh   (thresh),
            .rank     (rank_flat[i*IDX_W +: IDX_W])
         );
      end
   endgenerate

   lru_free_pick #(.LINES(LINES)) u_free (
      .valid    (line_valid),
      .any_free (any_free),
      .free_idx (free_idx)
   );

   lru_oldest_pick #(.LINES(LINES)) u_old (
      .rank_flat (rank_flat),
      .old_idx   (old_idx)
   );

   assign victim_line = any_free ? free_idx : old_idx;

endmodule

// File: rtl/lru_rank_tracker_chk.sv
`timescale 1ns/1ps
module lru_rank_tracker_chk #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_en,
   input logic                   acc_fill,
   input logic [IDX_W-1:0]       acc_line,
   input logic [LINES-1:0]       line_valid,
   input logic [IDX_W-1:0]       victim_line,
   input logic [LINES*IDX_W-1:0] rank_flat
);

   logic [IDX_W-1:0] victim_rank;
   logic [IDX_W-1:0] hit_rank;
   assign victim_rank = rank_flat[victim_line*IDX_W +: IDX_W];
   assign hit_rank    = rank_flat[acc_line*IDX_W +: IDX_W];

   AST_VICTIM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(&line_valid) |-> !line_valid[victim_line]);  // R2
   AST_VICTIM_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      (&line_valid) |-> (victim_rank == IDX_W'(LINES - 1)));  // R3
   AST_IGNORE_EMPTY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_fill && !line_valid[acc_line]) |=> $stable(rank_flat));  // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |=> $stable(rank_flat));  // R8

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         AST_TOUCH_TO_MRU: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && line_valid[i] && acc_line == IDX_W'(i))
            |=> (rank_flat[i*IDX_W +: IDX_W] == '0));  // R4
         AST_OLDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && !acc_fill && line_valid[acc_line] && line_valid[i]
             && rank_flat[i*IDX_W +: IDX_W] > hit_rank)
            |=> $stable(rank_flat[i*IDX_W +: IDX_W]));  // R4
         for (genvar j = i + 1; j < LINES; j++) begin : g_pair
            AST_RANK_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
               (line_valid[i] && line_valid[j])
               |-> (rank_flat[i*IDX_W +: IDX_W] != rank_flat[j*IDX_W +: IDX_W]));  // R9
         end
      end
   endgenerate

endmodule

bind lru_rank_tracker lru_rank_tracker_chk #(.LINES(LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_en      (acc_en),
   .acc_fill    (acc_fill),
   .acc_line    (acc_line),
   .line_valid  (line_valid),
   .victim_line (victim_line),
   .rank_flat   (rank_flat)
);

// File: tb/lru_rank_tracker_bench.sv
`timescale 1ns/1ps
module lru_rank_tracker_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic       acc_fill = 1'b0;
   logic [1:0] acc_line = '0;
   logic [3:0] line_valid = '0;
   logic [1:0] victim_line;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lru_rank_tracker #(.LINES(4)) u_lru_rank_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_en      (acc_en),
      .acc_fill    (acc_fill),
      .acc_line    (acc_line),
      .line_valid  (line_valid),
      .victim_line (victim_line)
   );

   // {acc_en, acc_fill, acc_line[1:0], line_valid before the edge[3:0], expected victim[1:0]}
   localparam int NSTEP = 17;
   localparam logic [9:0] STEPS [NSTEP] = '{
      {1'b1, 1'b1, 2'd0, 4'b0000, 2'd1},  // fill 0           R5 R10
      {1'b1, 1'b1, 2'd1, 4'b0001, 2'd2},  // fill 1           R5 R10
      {1'b1, 1'b1, 2'd2, 4'b0011, 2'd3},  // fill 2           R5 R10
      {1'b1, 1'b0, 2'd0, 4'b0111, 2'd3},  // hit 0 -> 0,2,1   R4 R10
      {1'b1, 1'b1, 2'd3, 4'b0111, 2'd1},  // fill 3 -> 1,3,2,0 R5 R3
      {1'b1, 1'b1, 2'd1, 4'b1111, 2'd2},  // replace 1 -> 2,0,3,1 R6 R10
      {1'b1, 1'b0, 2'd2, 4'b1111, 2'd0},  // -> 3,1,0,2       R4 R3
      {1'b1, 1'b0, 2'd0, 4'b1111, 2'd3},  // -> 0,2,1,3       R4
      {1'b1, 1'b0, 2'd3, 4'b1111, 2'd1},  // -> 1,3,2,0       R4
      {1'b1, 1'b0, 2'd3, 4'b1111, 2'd1},  // MRU hit, no change R4
      {1'b1, 1'b0, 2'd2, 4'b1111, 2'd1},  // -> 2,3,0,1       R4
      {1'b1, 1'b0, 2'd1, 4'b1101, 2'd1},  // hit on empty line ignored R7
      {1'b0, 1'b0, 2'd0, 4'b1111, 2'd1},  // idle, ranks kept R8 R7
      {1'b1, 1'b1, 2'd3, 4'b1111, 2'd1},  // replace mid rank -> 2,3,1,0 R6
      {1'b1, 1'b1, 2'd2, 4'b1011, 2'd1},  // gap fill -> 2,3,0,1 R5
      {1'b1, 1'b0, 2'd1, 4'b1111, 2'd0},  // -> 3,0,1,2       R4
      {1'b1, 1'b0, 2'd0, 4'b1111, 2'd3}   // -> 0,1,2,3       R4
   };

   task automatic check(input logic [1:0] exp, input string tag);
      checks++;
      if (victim_line !== exp) begin
         failures++;
         $display("FAIL %s victim actual=%0d expected=%0d", tag, victim_line, exp);
      end
   endtask

   // Drive one cycle, then update valid as the tag store would and settle
   task automatic step(input logic en, input logic fill, input logic [1:0] line,
                       input logic [3:0] vpre);
      @(negedge clk);
      acc_en = en; acc_fill = fill; acc_line = line; line_valid = vpre;
      @(posedge clk);
      #1;
      acc_en = 1'b0; acc_fill = 1'b0;
      line_valid = (en && fill) ? (vpre | (4'b0001 << line)) : vpre;
      #0.5;
   endtask

   task automatic set_valid(input logic [3:0] v);
      @(negedge clk);
      line_valid = v;
      #0.5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_en = 1'b0; acc_fill = 1'b0; line_valid = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      set_valid(4'b0000); check(2'd0, "R1 empty after reset");
      set_valid(4'b1111); check(2'd3, "R1 identity ranks");
      set_valid(4'b1010); check(2'd0, "R2 lowest empty");
      set_valid(4'b0101); check(2'd1, "R2 lowest empty");
      set_valid(4'b0111); check(2'd3, "R2 single empty");
      set_valid(4'b1011); check(2'd2, "R2 single empty");

      do_reset();
      for (int k = 0; k < NSTEP; k++) begin
         step(STEPS[k][9], STEPS[k][8], STEPS[k][7:6], STEPS[k][5:2]);
         check(STEPS[k][1:0], $sformatf("table step %0d R3 R4 R5 R6 R10", k));
      end

      step(1'b1, 1'b0, 2'd3, 4'b1111);
      check(2'd2, "R4 hit oldest before reset");
      do_reset();
      set_valid(4'b1111);
      check(2'd3, "R1 reset restores order");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule